// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block collects level-sensitive request lines from peripherals and a small set of request flags that software sets and clears. It resolves them into one vectored request for a processor. Every source has its own vector number and a 4-bit priority level set by software. The block raises its request output only for the best pending source whose level is strictly above the current priority. Software can write the current priority directly. A task that touches a shared resource raises the level to that resource's ceiling, and no other task sharing the resource can then preempt it.

The processor takes a request by reading the acknowledge register. That read returns the vector, saves the old current priority on a 16-entry LIFO and moves the current priority up to the winner's level. Writing the end-of-interrupt register pops the LIFO and restores the level that was saved. A handler started by a peripheral can set a software flag, so the rest of its work runs later at a lower level.

Software flags take vectors 0 to N_SW-1. Peripheral line i takes vector N_SW+i. The register port is synchronous, and read data appears one cycle after the read strobe.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_o is 0, irq_vec_o equals the no-request code NSRC (= N_SW+N_HW), and the current priority, all source levels, all software flags and both status bits read as 0.
- R2: Software flag j reports vector j and peripheral line i reports vector N_SW+i. irq_o and irq_vec_o are registered and reflect a change of inputs or state on the first clock edge after that change.
- R3: The level of source v is read and written in bits [3:0] at address 0x100+v. Level 0 disables the source even while its request is active.
- R4: irq_o is 1 only when the best pending level is strictly greater than the current priority.
- R5: Among pending enabled sources the highest level wins, and among equal levels the lowest vector wins.
- R6: The current priority is read and written in bits [3:0] at address 0x000, and raising it masks all sources at or below it.
- R7: A read of address 0x001 while a request is signalled returns its vector, pushes the old current priority and sets the current priority to the winner's level. With no request it returns NSRC and changes nothing.
- R8: Any write to address 0x002 pops the LIFO into the current priority, which restores nested levels in reverse order.
- R9: A pop with an empty LIFO sets the current priority to 0 and sets sticky status bit 0. A push onto a full LIFO (16 entries) is discarded and sets sticky status bit 1. The status is at address 0x003, and writing 1 to a bit clears it.
- R10: Writing a mask to 0x004 sets software flags and writing a mask to 0x005 clears them. A read of either address returns the flags. Flags persist through acknowledge and are arbitrated like peripheral sources.
- R11: Peripheral lines are level-sensitive, so a line that drops withdraws its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq_i | input | N_HW | Peripheral request levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (ignored when reg_wr is high) |
| reg_addr | input | 9 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq_o | output | 1 | Request to the processor |
| irq_vec_o | output | VW | Vector of the signalled request, NSRC when idle |

## Verification
Some properties are checked by assertions on every cycle. The signalled vector always stays in range. An accepted acknowledge always raises the current priority. A non-empty pop shrinks the LIFO by exactly one. The LIFO count never exceeds its depth. The status bits and software flags stay sticky until an explicit clear. Other behaviour can only be shown by the directed scenarios: which source wins a tie, the strict masking against the ceiling, the one-cycle latency, the restored levels on nested return, the disabling by level 0, and the underflow and overflow paths.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_SW  = 4,
  parameter int N_HW  = 28,
  parameter int DEPTH = 16,
  localparam int NSRC = N_SW + N_HW,
  localparam int VW   = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_HW-1:0] hw_irq_i,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [8:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq_o,
  output logic [VW-1:0]   irq_vec_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [8:0] A_CUR = 9'h000, A_ACK = 9'h001, A_EOI = 9'h002,
                         A_STAT = 9'h003, A_SET = 9'h004, A_CLR = 9'h005;

  logic [3:0]      prio [NSRC];
  logic [3:0]      stack [DEPTH];
  logic [3:0]      cur_pri, lvl_q, best_pri, prio_rd;
  logic [N_SW-1:0] swf;
  logic [CW-1:0]   cnt;
  logic            uf_q, of_q, irq_q;
  logic [VW-1:0]   vec_q, best_vec;
  logic [NSRC-1:0] pend;
  logic [31:0]     rdata_q;
  logic            rd_en, prio_hit, ack_go, eoi_go, full, empty;
  logic [7:0]      idx;
  logic            unused_bits;

  assign unused_bits = ^reg_wdata;
  assign pend      = {hw_irq_i, swf};
  assign idx       = reg_addr[7:0];
  assign rd_en     = reg_rd && !reg_wr;
  assign prio_hit  = reg_addr[8] && (int'(idx) < NSRC);
  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign ack_go    = rd_en && (reg_addr == A_ACK) && irq_q && (lvl_q > cur_pri);
  assign eoi_go    = reg_wr && (reg_addr == A_EOI);
  assign reg_rdata = rdata_q;
  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

  always_comb begin
    best_pri = '0;
    best_vec = VW'(NSRC);
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && prio[i] > best_pri) begin
        best_pri = prio[i];
        best_vec = VW'(i);
      end
  end

  always_comb begin
    prio_rd = '0;
    for (int i = 0; i < NSRC; i++)
      if (idx == 8'(i)) prio_rd = prio[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
      swf <= '0;
    end else if (reg_wr) begin
      if (prio_hit)
        for (int i = 0; i < NSRC; i++)
          if (idx == 8'(i)) prio[i] <= reg_wdata[3:0];
      if (reg_addr == A_SET) swf <= swf | reg_wdata[N_SW-1:0];
      if (reg_addr == A_CLR) swf <= swf & ~reg_wdata[N_SW-1:0];
    end
  end

  always_ff @(posedge clk)
    if (ack_go && !full) stack[IW'(cnt)] <= cur_pri;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pri <= '0;
      cnt     <= '0;
      uf_q    <= 1'b0;
      of_q    <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CUR) cur_pri <= reg_wdata[3:0];
      else if (ack_go) begin
        cur_pri <= lvl_q;
        if (full) of_q <= 1'b1;
        else cnt <= cnt + CW'(1);
      end else if (eoi_go) begin
        if (empty) begin
          cur_pri <= '0;
          uf_q    <= 1'b1;
        end else begin
          cur_pri <= stack[IW'(cnt - CW'(1))];
          cnt     <= cnt - CW'(1);
        end
      end
      if (reg_wr && reg_addr == A_STAT) begin
        if (reg_wdata[0]) uf_q <= 1'b0;
        if (reg_wdata[1]) of_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= VW'(NSRC);
      lvl_q <= '0;
    end else begin
      irq_q <= best_pri > cur_pri;
      vec_q <= (best_pri > cur_pri) ? best_vec : VW'(NSRC);
      lvl_q <= best_pri;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else begin
      rdata_q <= '0;
      if (rd_en) begin
        if (prio_hit) rdata_q <= 32'(prio_rd);
        else case (reg_addr)
          A_CUR:        rdata_q <= 32'(cur_pri);
          A_ACK:        rdata_q <= ack_go ? 32'(vec_q) : 32'(NSRC);
          A_STAT:       rdata_q <= {30'd0, of_q, uf_q};
          A_SET, A_CLR: rdata_q <= 32'(swf);
          default:      rdata_q <= '0;
        endcase
      end
    end
  end

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_vec_o < VW'(NSRC)) else $error("vector out of range"); // R2
  AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go && !reg_wr |=> cur_pri > $past(cur_pri)) else $error("ack did not raise level"); // R7
  AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_go && !empty |=> cnt == $past(cnt) - CW'(1)) else $error("pop lost count"); // R8
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)) else $error("stack count overflow"); // R9
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q && !(reg_wr && reg_addr == A_STAT && reg_wdata[0]) |=> uf_q) else $error("underflow bit lost"); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_CLR) |=> (swf & $past(swf)) == $past(swf)) else $error("flag dropped"); // R10
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  localparam int NSW = 4, NHW = 28, N = NSW + NHW, VW = $clog2(N + 1);
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NHW-1:0] hw = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  logic [VW-1:0] vec;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_intc #(.N_SW(NSW), .N_HW(NHW), .DEPTH(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_irq_i(hw), .reg_wr(wr), .reg_rd(rd),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq), .irq_vec_o(vec));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; hw = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wreg(logic [8:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 irq", 32'(irq), 0);
    check("R1 vec", 32'(vec), N);
    rreg(9'h000, d); check("R1 cur", d, 0);
    rreg(9'h105, d); check("R1 prio", d, 0);
    rreg(9'h004, d); check("R1 flags", d, 0);
    rreg(9'h003, d); check("R1 status", d, 0);
  endtask

  task automatic t_vector();
    do_reset();
    wreg(9'h107, 5);
    settle();
    @(negedge clk); hw[3] = 1'b1;
    #1 check("R2 before edge", 32'(irq), 0);
    @(negedge clk);
    check("R2 irq one cycle", 32'(irq), 1);
    check("R2 vector", 32'(vec), 7);
    hw[3] = 1'b0;
    @(negedge clk);
    check("R11 withdraw", 32'(irq), 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    do_reset();
    hw[5] = 1'b1; settle();
    check("R3 level0 disabled", 32'(irq), 0);
    wreg(9'h109, 11); settle();
    check("R3 enabled", 32'(irq), 1);
    rreg(9'h109, d); check("R3 readback", d, 11);
    wreg(9'h109, 0); settle();
    check("R3 disable again", 32'(irq), 0);
  endtask

  task automatic t_ceiling();
    logic [31:0] d;
    do_reset();
    wreg(9'h000, 5);
    rreg(9'h000, d); check("R6 cur readback", d, 5);
    wreg(9'h10C, 5); hw[8] = 1'b1; settle();
    check("R4 equal level masked", 32'(irq), 0);
    wreg(9'h10C, 6); settle();
    check("R4 above ceiling", 32'(irq), 1);
    wreg(9'h000, 15); settle();
    check("R6 ceiling masks", 32'(irq), 0);
  endtask

  task automatic t_ties();
    do_reset();
    wreg(9'h10A, 9); wreg(9'h114, 9);
    hw[6] = 1'b1; hw[16] = 1'b1; settle();
    check("R5 tie lowest vector", 32'(vec), 10);
    wreg(9'h114, 10); settle();
    check("R5 higher level wins", 32'(vec), 20);
  endtask

  task automatic t_nesting();
    logic [31:0] d;
    do_reset();
    rreg(9'h001, d); check("R7 ack idle code", d, N);
    rreg(9'h000, d); check("R7 idle ack no change", d, 0);
    wreg(9'h108, 4); wreg(9'h110, 8);
    hw[4] = 1'b1; settle();
    rreg(9'h001, d); check("R7 ack vector", d, 8);
    rreg(9'h000, d); check("R7 level raised", d, 4);
    hw[12] = 1'b1; settle();
    check("R7 preempt vector", 32'(vec), 16);
    rreg(9'h001, d); check("R7 nested ack", d, 16);
    rreg(9'h000, d); check("R7 nested level", d, 8);
    hw = '0;
    wreg(9'h002, 0);
    rreg(9'h000, d); check("R8 pop restores 4", d, 4);
    wreg(9'h002, 0);
    rreg(9'h000, d); check("R8 pop restores 0", d, 0);
    rreg(9'h003, d); check("R8 no underflow", d, 0);
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    do_reset();
    wreg(9'h000, 3);
    wreg(9'h002, 0);
    rreg(9'h000, d); check("R9 underflow level", d, 0);
    rreg(9'h003, d); check("R9 underflow bit", d, 1);
    wreg(9'h000, 2);
    rreg(9'h003, d); check("R9 sticky", d, 1);
    wreg(9'h003, 1);
    rreg(9'h003, d); check("R9 clear", d, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    do_reset();
    wreg(9'h10C, 1); hw[8] = 1'b1;
    for (int k = 0; k < 17; k++) begin
      settle();
      rreg(9'h001, d); check("R9 repeated ack", d, 12);
      wreg(9'h000, 0);
    end
    rreg(9'h003, d); check("R9 overflow bit", d, 2);
    hw = '0;
    for (int k = 0; k < 16; k++) wreg(9'h002, 0);
    rreg(9'h003, d); check("R9 sixteen pops ok", d, 2);
    wreg(9'h002, 0);
    rreg(9'h003, d); check("R9 then underflow", d, 3);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    do_reset();
    wreg(9'h102, 7); wreg(9'h105, 7);
    hw[1] = 1'b1;
    wreg(9'h004, 4);
    rreg(9'h005, d); check("R10 flag readback", d, 4);
    settle();
    check("R10 flag wins tie", 32'(vec), 2);
    rreg(9'h001, d); check("R10 ack flag", d, 2);
    rreg(9'h004, d); check("R10 flag persists", d, 4);
    wreg(9'h005, 4);
    rreg(9'h004, d); check("R10 flag cleared", d, 0);
    wreg(9'h002, 0); settle();
    check("R10 peripheral next", 32'(vec), 5);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_vector();
    t_disable();
    t_ceiling();
    t_ties();
    t_nesting();
    t_underflow();
    t_overflow();
    t_flags();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule